// File: doc/BRIEF.md
# Audio Master Clock Enable Generator

This block turns a fast audio source clock into a set of single-cycle enables that pace an audio serial engine. Two divisor fields in a 32-bit mode word set the ratios. A master-clock enable fires once every DIV+1 source cycles. A frame enable fires once every 32×(FS+1) source cycles, so the master clock sits at 32×(FS+1)/(DIV+1) times the frame rate. For example, DIV=7 with FS=63 gives 256 fs, DIV=7 with FS=15 gives 64 fs, and DIV=0 with FS=47 gives 1536 fs. When the mode word selects bus-master operation, the block also produces a bit-clock enable that fires 64 times per frame and a word-select level for a two-slot frame with 32 bits per slot. These come from counters that share one start point.

A controller with three named states governs the generator. IDLE holds every counter at zero and keeps every output low. A clock-on command moves IDLE to ARM and captures the mode word. ARM lasts exactly one cycle, with the counters held clear, and then moves to RUN. RUN counts and emits enables. A clock-off command moves any state back to IDLE. If clock-on and clock-off arrive together, clock-off wins. The mode word is read only on the IDLE-to-ARM transition, so new divisor values apply from the next enable onward. A separate mode bit chooses what drives the bit clock pin. With the bit set, a master clock is generated on its own output. With the bit clear, no master clock is produced, and a steering flag tells the pad logic to drive the bit clock pin from the selected clock.

Top module: `audio_mclk_gen`

## Requirements
- R1: The mode word is decoded as follows: bit 0 = 1 selects bus master, bits 21:16 hold DIV, bits 29:24 hold FS, and bit 30 = 1 selects master-clock generation.
- R2: Reset leaves the block in IDLE with `active`, `mck_en`, `fs_en`, `bclk_en`, `ws` and `bclk_direct` all low.
- R3: A clock-on command seen in IDLE enters ARM on the next edge, and ARM lasts exactly one cycle. During ARM all outputs stay low. The first cycle of RUN is counted as cycle n=0, and `active` is high throughout RUN.
- R4: In RUN, `mck_en` is high in exactly those cycles where n mod (DIV+1) = DIV, and only when master-clock generation is selected.
- R5: In RUN with master mode, `fs_en` is high exactly where n mod L = L−1, with L = 32×(FS+1).
- R6: In RUN with master mode, `bclk_en` is high exactly where n mod (L/64) = L/64−1, which gives 64 pulses per frame. FS must be odd, and every frame-end cycle is also a bit-clock cycle.
- R7: In RUN with master mode, `ws` is low for the first half of each frame (n mod L < L/2) and high for the second half. Outside master RUN, `ws` is low.
- R8: `bclk_direct` is high in RUN exactly when master-clock generation is not selected. In slave mode, `fs_en`, `bclk_en` and `ws` stay low.
- R9: A clock-off command returns the block to IDLE on the next edge from any state, and it wins over a simultaneous clock-on. The next enable restarts every count at n=0.
- R10: While the block is in RUN, changes to the mode word and further clock-on commands have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Audio source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_on | input | 1 | Single-cycle start command |
| clk_off | input | 1 | Single-cycle stop command |
| mode_word | input | 32 | Mode word carrying the master bit, DIV, FS and the master-clock generation bit |
| active | output | 1 | High while the generator is in RUN |
| mck_en | output | 1 | Master-clock enable pulse |
| fs_en | output | 1 | Frame-end enable pulse |
| bclk_en | output | 1 | Bit-clock enable pulse |
| ws | output | 1 | Word select: low for the first slot, high for the second |
| bclk_direct | output | 1 | Steers the selected clock straight onto the bit clock pin |

## Verification
The assertions assume that FS is odd whenever a master-mode run is active. Under that condition a frame divides into 64 whole bit periods, and a frame-end cycle always falls on a bit-clock cycle. The assertions also assume that the captured configuration only changes outside RUN. The sweep meets the first assumption by programming only odd FS values. It tests the second directly: right after each start it overwrites the mode word with its complement, and a few cycles later it issues a redundant clock-on, then checks that every output still follows the values captured at start.

// File: rtl/amg_pkg.sv
package amg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } amg_state_e;

endpackage

// File: rtl/amg_wrap_cnt.sv
module amg_wrap_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         tick
);

    logic at_limit;

    assign at_limit = (cnt == limit);
    assign tick     = run && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (at_limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    // R9: a held counter restarts from zero
    p_clear_when_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/amg_ctrl.sv
module amg_ctrl
    import amg_pkg::*;
#(
    parameter int MODE_W     = 32,
    parameter int DIV_W      = 6,
    parameter int FS_W       = 6,
    parameter int MASTER_BIT = 0,
    parameter int DIV_LSB    = 16,
    parameter int FS_LSB     = 24,
    parameter int MCKGEN_BIT = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_on,
    input  logic              cmd_off,
    input  logic [MODE_W-1:0] mode_word,
    output amg_state_e        state_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [FS_W-1:0]   fs_q,
    output logic              master_q,
    output logic              mck_gen_q
);

    amg_state_e state_d;
    logic       capture;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_on && !cmd_off) state_d = ST_ARM;
            ST_ARM:  state_d = cmd_off ? ST_IDLE : ST_RUN;
            ST_RUN:  if (cmd_off) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign capture = (state_q == ST_IDLE) && cmd_on && !cmd_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= '0;
            fs_q      <= '0;
            master_q  <= 1'b0;
            mck_gen_q <= 1'b0;
        end else if (capture) begin
            div_q     <= mode_word[DIV_LSB +: DIV_W];
            fs_q      <= mode_word[FS_LSB +: FS_W];
            master_q  <= mode_word[MASTER_BIT];
            mck_gen_q <= mode_word[MCKGEN_BIT];
        end
    end

    // R3: the arming state lasts a single cycle
    p_arm_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> (state_q != ST_ARM));

    // R9: stop command always lands in idle
    p_off_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_off |=> (state_q == ST_IDLE));

    // R10: configuration is frozen while running
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> ((state_q != ST_RUN) ||
            ($stable(div_q) && $stable(fs_q) && $stable(master_q) && $stable(mck_gen_q))));

endmodule

// File: rtl/audio_mclk_gen.sv
module audio_mclk_gen
    import amg_pkg::*;
#(
    parameter int MODE_W         = 32,
    parameter int DIV_W          = 6,
    parameter int FS_W           = 6,
    parameter int MASTER_BIT     = 0,
    parameter int DIV_LSB        = 16,
    parameter int FS_LSB         = 24,
    parameter int MCKGEN_BIT     = 30,
    parameter int SLOT_UNIT      = 32,
    parameter int BITS_PER_FRAME = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_on,
    input  logic              clk_off,
    input  logic [MODE_W-1:0] mode_word,
    output logic              active,
    output logic              mck_en,
    output logic              fs_en,
    output logic              bclk_en,
    output logic              ws,
    output logic              bclk_direct
);

    localparam int UNIT_LOG = $clog2(SLOT_UNIT);
    localparam int BPF_LOG  = $clog2(BITS_PER_FRAME);
    localparam int FRAME_W  = FS_W + UNIT_LOG;

    amg_state_e         state_q;
    logic [DIV_W-1:0]   div_q;
    logic [FS_W-1:0]    fs_q;
    logic               master_q;
    logic               mck_gen_q;
    logic               run;

    logic [FRAME_W:0]   frame_len;
    logic [FRAME_W-1:0] frame_last;
    logic [FRAME_W-1:0] half_last;
    logic [FRAME_W-1:0] bit_last;

    logic [DIV_W-1:0]   mck_cnt;
    logic [FRAME_W-1:0] frm_cnt;
    logic [FRAME_W-1:0] bit_cnt;
    logic               mck_tick;
    logic               frm_tick;
    logic               bit_tick;
    logic               ws_q;

    amg_ctrl #(
        .MODE_W     (MODE_W),
        .DIV_W      (DIV_W),
        .FS_W       (FS_W),
        .MASTER_BIT (MASTER_BIT),
        .DIV_LSB    (DIV_LSB),
        .FS_LSB     (FS_LSB),
        .MCKGEN_BIT (MCKGEN_BIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_on    (clk_on),
        .cmd_off   (clk_off),
        .mode_word (mode_word),
        .state_q   (state_q),
        .div_q     (div_q),
        .fs_q      (fs_q),
        .master_q  (master_q),
        .mck_gen_q (mck_gen_q)
    );

    assign run = (state_q == ST_RUN);

    always_comb begin
        frame_len  = ((FRAME_W+1)'(fs_q) + (FRAME_W+1)'(1)) << UNIT_LOG;
        frame_last = FRAME_W'(frame_len - (FRAME_W+1)'(1));
        half_last  = frame_last >> 1;
        bit_last   = FRAME_W'((frame_len >> BPF_LOG) - (FRAME_W+1)'(1));
    end

    amg_wrap_cnt #(.W(DIV_W)) u_mck_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (div_q),
        .cnt   (mck_cnt),
        .tick  (mck_tick)
    );

    amg_wrap_cnt #(.W(FRAME_W)) u_frm_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (frame_last),
        .cnt   (frm_cnt),
        .tick  (frm_tick)
    );

    amg_wrap_cnt #(.W(FRAME_W)) u_bit_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (bit_last),
        .cnt   (bit_cnt),
        .tick  (bit_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q <= 1'b0;
        end else if (!run) begin
            ws_q <= 1'b0;
        end else if ((frm_cnt == half_last) || (frm_cnt == frame_last)) begin
            ws_q <= ~ws_q;
        end
    end

    always_comb begin
        active      = run;
        mck_en      = mck_tick && mck_gen_q;
        fs_en       = frm_tick && master_q;
        bclk_en     = bit_tick && master_q;
        ws          = ws_q && master_q && run;
        bclk_direct = run && !mck_gen_q;
    end

    // R2: nothing leaves the block outside the running state
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!mck_en && !fs_en && !bclk_en && !ws && !bclk_direct));

    // R6: master runs need an odd FS so a frame holds whole bit periods
    p_even_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && master_q) |-> fs_q[0]);

    // R6: a frame end coincides with a bit-clock end
    p_frame_on_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fs_en |-> bclk_en);

    // R7: each frame starts in the first slot
    p_ws_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fs_en |=> !ws);

    // R4: with DIV above zero master-clock pulses are never back to back
    p_mck_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mck_en && (div_q != '0)) |=> !mck_en);

endmodule

// File: tb/audio_mclk_gen_tb.sv
module audio_mclk_gen_tb;

    logic        clk;
    logic        rst_n;
    logic        clk_on;
    logic        clk_off;
    logic [31:0] mode_word;
    logic        active;
    logic        mck_en;
    logic        fs_en;
    logic        bclk_en;
    logic        ws;
    logic        bclk_direct;

    int  n_chk;
    int  n_fail;
    bit  done;

    audio_mclk_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_on      (clk_on),
        .clk_off     (clk_off),
        .mode_word   (mode_word),
        .active      (active),
        .mck_en      (mck_en),
        .fs_en       (fs_en),
        .bclk_en     (bclk_en),
        .ws          (ws),
        .bclk_direct (bclk_direct)
    );

    initial clk = 1'b0;
    always #10ns clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_all_low(input string req);
        chk(req, "active", active, 1'b0);
        chk(req, "mck_en", mck_en, 1'b0);
        chk(req, "fs_en", fs_en, 1'b0);
        chk(req, "bclk_en", bclk_en, 1'b0);
        chk(req, "ws", ws, 1'b0);
        chk(req, "bclk_direct", bclk_direct, 1'b0);
    endtask

    // R1: bit 0 master, 21:16 DIV, 29:24 FS, 30 master-clock generation
    function automatic logic [31:0] make_word(input int d, input int f, input bit m, input bit g);
        logic [31:0] w;
        w = '0;
        w[0] = m;
        w[21:16] = d[5:0];
        w[29:24] = f[5:0];
        w[30] = g;
        return w;
    endfunction

    task automatic run_cfg(input int d, input int f, input bit m, input bit g);
        logic [31:0] w;
        int L;
        int P;
        int ncyc;
        w = make_word(d, f, m, g);
        L = 32 * (f + 1);
        P = L / 64;
        ncyc = 2 * L + 3;
        @(negedge clk);
        mode_word = w;
        clk_on = 1'b1;
        @(negedge clk);
        clk_on = 1'b0;
        chk_all_low("R3");
        @(negedge clk);
        for (int n = 0; n < ncyc; n++) begin
            chk("R3", "active", active, 1'b1);
            chk("R4", "mck_en", mck_en, g && ((n % (d + 1)) == d));
            chk("R5", "fs_en", fs_en, m && ((n % L) == L - 1));
            chk("R6", "bclk_en", bclk_en, m && ((n % P) == P - 1));
            chk("R7", "ws", ws, m && ((n % L) >= L / 2));
            chk("R8", "bclk_direct", bclk_direct, !g);
            if (n == 0) mode_word = ~w;     // R10: ignored while running
            clk_on = (n == 3);              // R10: redundant start ignored
            @(negedge clk);
        end
        clk_on = 1'b0;
        clk_off = 1'b1;
        @(negedge clk);
        clk_off = 1'b0;
        chk_all_low("R9");
        mode_word = '0;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int ds[4];
        int fs_list[4];
        n_chk = 0;
        n_fail = 0;
        done = 1'b0;
        rst_n = 1'b0;
        clk_on = 1'b0;
        clk_off = 1'b0;
        mode_word = '0;
        ds = '{0, 1, 3, 7};
        fs_list = '{1, 3, 7, 15};
        repeat (3) @(negedge clk);
        chk_all_low("R2");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all_low("R2");

        // R9: stop wins over a simultaneous start
        mode_word = make_word(1, 1, 1'b1, 1'b1);
        clk_on = 1'b1;
        clk_off = 1'b1;
        @(negedge clk);
        clk_on = 1'b0;
        clk_off = 1'b0;
        chk_all_low("R9");
        @(negedge clk);
        chk_all_low("R9");

        // R9: stop during the arming cycle
        clk_on = 1'b1;
        @(negedge clk);
        clk_on = 1'b0;
        clk_off = 1'b1;
        @(negedge clk);
        clk_off = 1'b0;
        chk_all_low("R9");
        @(negedge clk);
        chk_all_low("R9");

        foreach (ds[i]) begin
            foreach (fs_list[j]) begin
                run_cfg(ds[i], fs_list[j], 1'b1, 1'b1);
                run_cfg(ds[i], fs_list[j], 1'b1, 1'b0);
                run_cfg(ds[i], fs_list[j], 1'b0, 1'b1);
            end
        end

        // R4: largest divider field
        run_cfg(63, 1, 1'b1, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule